// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counter Timer Bank

This block divides the system clock with a single shared prescaler into a periodic one-cycle tick. The tick paces a parameterised number (1 to 7) of independent down-counting timers. Each timer has its own reload value, an enable bit, an auto-reload bit and a self-clearing load bit. A timer raises a one-cycle interrupt pulse when it underflows. It then either reloads and keeps running, or stops.

Timer interrupts land on a parameterised vector of interrupt lines. In separate mode the first timer drives line `IRQ_BASE` and each following timer drives the next line up. In shared mode every timer drives line `IRQ_BASE`. When the watchdog option is on, the last timer is enabled at reset with a preset timeout. Its first underflow sets a sticky watchdog output that only reset clears.

Software reaches the block through a plain write strobe and a combinational read port. Address bits [4:2] select a unit: 0 is the prescaler and k+1 is timer k. Address bits [1:0] select a field: 0 is the counter (read-only), 1 is the reload value, and 2 is control (timers only). Control bit 0 is enable, bit 1 is auto-reload and bit 2 is load.

Top module: `tick_timer_bank`

## Requirements
- R1: The prescaler counter decrements every clock cycle. When it is zero it reloads, and `tick_o` is high for exactly one cycle, so ticks are spaced by reload+1 cycles. The prescaler reload resets to `PRE_RST`, and a newly written reload takes effect at the next underflow.
- R2: An enabled timer decrements once per tick. On a tick with the counter at zero, the timer underflows and its interrupt pulse is high for the single following cycle. No interrupt occurs at any other time.
- R3: With auto-reload set (control bit 1), an underflow copies the reload value into the counter and the timer stays enabled, so it underflows again every reload+1 ticks.
- R4: With auto-reload clear, an underflow clears the enable bit and the counter wraps to all ones. No further interrupt follows.
- R5: Writing control with bit 2 set copies the reload value into the counter one cycle after the write. Control bit 2 always reads as 0.
- R6: In separate mode (`SEP_IRQ`=1), timer k pulses only line `IRQ_BASE`+k of `irq_o`.
- R7: In shared mode (`SEP_IRQ`=0), every timer pulses line `IRQ_BASE` of `irq_o`.
- R8: After reset, ordinary timers have counter, reload and control equal to 0. With `WDOG_EN` set, the last timer has counter and reload equal to `WDOG_INIT` and reads control value 1 (enabled, no auto-reload).
- R9: `wdog_o` is 0 after reset. It goes high the cycle after the last timer's interrupt pulse and stays high until reset.
- R10: Reads are combinational. For unit 0, field 0 returns the prescaler counter and field 1 its reload. For timer units, field 0 returns the counter, field 1 the reload, and field 2 returns enable in bit 0 and auto-reload in bit 1.
- R11: A disabled timer with no load pending holds its counter across ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: unit in [4:2], field in [1:0] |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address, same layout as wr_addr |
| rd_data | output | 32 | Combinational read data |
| tick_o | output | 1 | One-cycle prescaler tick |
| irq_o | output | IRQ_LINES | Interrupt pulse lines |
| wdog_o | output | 1 | Sticky watchdog expiry flag |

## Verification
Each interrupt appears on `irq_o` in the cycle after the clock edge that consumes the tick with the counter at zero. The bench counts `tick_o` pulses at falling edges and books each interrupt into the scoreboard for the next falling edge. Load takes effect one edge after the write, and `wdog_o` rises one edge after the last timer's interrupt. Reads are sampled a short delay after the address changes, with no clock in between. Two instances, one per interrupt mode, receive identical stimulus, so each scoreboard entry checks the separate-line and the shared-line routing in the same cycle.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int CTL_EN = 0;
    localparam int CTL_AR = 1;
    localparam int CTL_LD = 2;
    localparam int CTL_W  = 3;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;
endpackage

// File: rtl/ttb_prescaler.sv
module ttb_prescaler #(
    parameter int PRE_W   = 8,
    parameter int PRE_RST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_rld,
    input  logic [PRE_W-1:0] wdata,
    output logic             tick,
    output logic [PRE_W-1:0] cnt,
    output logic [PRE_W-1:0] rld
);
    localparam logic [PRE_W-1:0] RST_RLD = PRE_W'(PRE_RST);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] rld;
        logic             tick;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == '0) begin
            st_d.cnt  = st_q.rld;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_rld) begin
            st_d.rld = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= RST_RLD;
            st_q.rld  <= RST_RLD;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;
    assign cnt  = st_q.cnt;
    assign rld  = st_q.rld;

    // R1
    tick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> st_q.cnt == $past(st_q.rld));
endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
    import ttb_pkg::*;
#(
    parameter int          W         = 16,
    parameter bit          IS_WDOG   = 1'b0,
    parameter logic [31:0] WDOG_INIT = 32'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_rld,
    input  logic             wr_ctl,
    input  logic [W-1:0]     wdata,
    input  logic [CTL_W-1:0] ctl_in,
    output logic [W-1:0]     cnt,
    output logic [W-1:0]     rld,
    output logic             en,
    output logic             ar,
    output logic             irq
);
    localparam logic [W-1:0] RST_CNT = IS_WDOG ? WDOG_INIT[W-1:0] : '0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
        logic         en;
        logic         ar;
        logic         ld;
        logic         irq;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.ld  = 1'b0;
        if (st_q.ld) begin
            st_d.cnt = st_q.rld;
        end else if (tick && st_q.en) begin
            if (st_q.cnt == '0) begin
                st_d.irq = 1'b1;
                if (st_q.ar) begin
                    st_d.cnt = st_q.rld;
                end else begin
                    st_d.cnt = '1;
                    st_d.en  = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (wr_rld) begin
            st_d.rld = wdata;
        end
        if (wr_ctl) begin
            st_d.en = ctl_in[CTL_EN];
            st_d.ar = ctl_in[CTL_AR];
            st_d.ld = ctl_in[CTL_LD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= RST_CNT;
            st_q.rld <= RST_CNT;
            st_q.en  <= IS_WDOG;
            st_q.ar  <= 1'b0;
            st_q.ld  <= 1'b0;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign rld = st_q.rld;
    assign en  = st_q.en;
    assign ar  = st_q.ar;
    assign irq = st_q.irq;

    // R5
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ld |=> st_q.cnt == $past(st_q.rld));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !st_q.ld) |=> st_q.cnt == $past(st_q.cnt));

    // R2
    irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(tick) && $past(st_q.en));
endmodule

// File: rtl/ttb_regport.sv
module ttb_regport
    import ttb_pkg::*;
#(
    parameter int N_TMR = 3,
    parameter int PRE_W = 8,
    parameter int TMR_W = 16
) (
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [PRE_W-1:0]             pre_cnt,
    input  logic [PRE_W-1:0]             pre_rld,
    input  logic [N_TMR-1:0][TMR_W-1:0]  ch_cnt,
    input  logic [N_TMR-1:0][TMR_W-1:0]  ch_rld,
    input  logic [N_TMR-1:0]             ch_en,
    input  logic [N_TMR-1:0]             ch_ar,
    output logic                         pre_wr,
    output logic [N_TMR-1:0]             ch_wr_rld,
    output logic [N_TMR-1:0]             ch_wr_ctl,
    output logic [DATA_W-1:0]            rd_data
);
    logic [2:0] wr_unit, rd_unit;
    sel_e       wr_sel, rd_sel;

    assign wr_unit = wr_addr[4:2];
    assign wr_sel  = sel_e'(wr_addr[1:0]);
    assign rd_unit = rd_addr[4:2];
    assign rd_sel  = sel_e'(rd_addr[1:0]);

    assign pre_wr = wr_en && (wr_unit == 3'd0) && (wr_sel == SEL_RELOAD);

    for (genvar k = 0; k < N_TMR; k++) begin : g_dec
        assign ch_wr_rld[k] = wr_en && (wr_unit == 3'(k + 1)) && (wr_sel == SEL_RELOAD);
        assign ch_wr_ctl[k] = wr_en && (wr_unit == 3'(k + 1)) && (wr_sel == SEL_CTRL);
    end

    always_comb begin
        rd_data = '0;
        if (rd_unit == 3'd0) begin
            case (rd_sel)
                SEL_COUNT:  rd_data[PRE_W-1:0] = pre_cnt;
                SEL_RELOAD: rd_data[PRE_W-1:0] = pre_rld;
                default:    rd_data = '0;
            endcase
        end
        for (int k = 0; k < N_TMR; k++) begin
            if (rd_unit == 3'(k + 1)) begin
                case (rd_sel)
                    SEL_COUNT:  rd_data[TMR_W-1:0] = ch_cnt[k];
                    SEL_RELOAD: rd_data[TMR_W-1:0] = ch_rld[k];
                    SEL_CTRL: begin
                        rd_data[CTL_EN] = ch_en[k];
                        rd_data[CTL_AR] = ch_ar[k];
                    end
                    default:    rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import ttb_pkg::*;
#(
    parameter int          PRE_W     = 8,
    parameter int          TMR_W     = 16,
    parameter int          N_TMR     = 3,
    parameter int          IRQ_LINES = 16,
    parameter int          IRQ_BASE  = 5,
    parameter bit          SEP_IRQ   = 1'b1,
    parameter int          PRE_RST   = 3,
    parameter bit          WDOG_EN   = 1'b1,
    parameter logic [31:0] WDOG_INIT = 32'd1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [4:0]           wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [4:0]           rd_addr,
    output logic [31:0]          rd_data,
    output logic                 tick_o,
    output logic [IRQ_LINES-1:0] irq_o,
    output logic                 wdog_o
);
    localparam int LAST   = N_TMR - 1;
    localparam int USED_A = (PRE_W > TMR_W) ? PRE_W : TMR_W;
    localparam int USED_W = (USED_A > CTL_W) ? USED_A : CTL_W;

    logic                        pre_wr;
    logic [PRE_W-1:0]            pre_cnt, pre_rld;
    logic [N_TMR-1:0][TMR_W-1:0] ch_cnt, ch_rld;
    logic [N_TMR-1:0]            ch_en, ch_ar, ch_irq, ch_wr_rld, ch_wr_ctl;

    if (USED_W < 32) begin : g_unused
        logic unused_wdata;
        assign unused_wdata = ^wr_data[31:USED_W];
    end

    ttb_prescaler #(.PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_rld (pre_wr),
        .wdata  (wr_data[PRE_W-1:0]),
        .tick   (tick_o),
        .cnt    (pre_cnt),
        .rld    (pre_rld)
    );

    for (genvar k = 0; k < N_TMR; k++) begin : g_ch
        ttb_channel #(
            .W         (TMR_W),
            .IS_WDOG   (WDOG_EN && (k == LAST)),
            .WDOG_INIT (WDOG_INIT)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_o),
            .wr_rld (ch_wr_rld[k]),
            .wr_ctl (ch_wr_ctl[k]),
            .wdata  (wr_data[TMR_W-1:0]),
            .ctl_in (wr_data[CTL_W-1:0]),
            .cnt    (ch_cnt[k]),
            .rld    (ch_rld[k]),
            .en     (ch_en[k]),
            .ar     (ch_ar[k]),
            .irq    (ch_irq[k])
        );
    end

    ttb_regport #(.N_TMR(N_TMR), .PRE_W(PRE_W), .TMR_W(TMR_W)) u_reg (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .pre_cnt   (pre_cnt),
        .pre_rld   (pre_rld),
        .ch_cnt    (ch_cnt),
        .ch_rld    (ch_rld),
        .ch_en     (ch_en),
        .ch_ar     (ch_ar),
        .pre_wr    (pre_wr),
        .ch_wr_rld (ch_wr_rld),
        .ch_wr_ctl (ch_wr_ctl),
        .rd_data   (rd_data)
    );

    always_comb begin
        irq_o = '0;
        for (int k = 0; k < N_TMR; k++) begin
            if (SEP_IRQ) irq_o[IRQ_BASE + k] = irq_o[IRQ_BASE + k] | ch_irq[k];
            else         irq_o[IRQ_BASE]     = irq_o[IRQ_BASE] | ch_irq[k];
        end
    end

    logic wdog_d, wdog_q;

    always_comb begin
        wdog_d = wdog_q;
        if (WDOG_EN && ch_irq[LAST]) wdog_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdog_q <= 1'b0;
        else        wdog_q <= wdog_d;
    end

    assign wdog_o = wdog_q;

    // R9
    wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_o |=> wdog_o);

    // R9
    wdog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_o) |-> $past(ch_irq[LAST]));

    // R2
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> $past(tick_o));
endmodule

// File: tb/sim_tick_timer_bank.sv
module sim_tick_timer_bank;
    import ttb_pkg::*;

    localparam int BASE = 5;
    localparam int WD   = 10;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rdata0, rdata1;
    logic        tick0, tick1, wdog0, wdog1;
    logic [15:0] irq0, irq1;

    always #2 clk = ~clk;

    tick_timer_bank #(.PRE_W(8), .TMR_W(16), .N_TMR(3), .IRQ_LINES(16), .IRQ_BASE(BASE),
        .SEP_IRQ(1'b1), .PRE_RST(3), .WDOG_EN(1'b1), .WDOG_INIT(WD)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rdata0), .tick_o(tick0), .irq_o(irq0), .wdog_o(wdog0));

    tick_timer_bank #(.PRE_W(8), .TMR_W(16), .N_TMR(3), .IRQ_LINES(16), .IRQ_BASE(BASE),
        .SEP_IRQ(1'b0), .PRE_RST(3), .WDOG_EN(1'b1), .WDOG_INIT(WD)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rdata1), .tick_o(tick1), .irq_o(irq1), .wdog_o(wdog1));

    typedef struct { int ch; int at; } exp_t;
    exp_t sb[$];
    int   cyc = 0, checks = 0, fails = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] ad(input int unit, input sel_e s);
        return {3'(unit), s};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].at == cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk(irq0 == 16'(1 << (BASE + e.ch)), "R6 separate line", irq0, 16'(1 << (BASE + e.ch)));
                chk(irq1 == 16'(1 << BASE), "R7 shared line", irq1, 16'(1 << BASE));
            end else if (irq0 != 0 || irq1 != 0) begin
                chk(1'b0, "R2 unexpected interrupt", {irq0, irq1}, 0);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v0, output logic [31:0] v1);
        rd_addr = a;
        #1;
        v0 = rdata0;
        v1 = rdata1;
    endtask

    // driver: counts ticks and books each expected interrupt
    task automatic count_uf(input int ch, input int L, input int reps);
        int n = 0;
        int got = 0;
        while (got < reps) begin
            if (tick0) begin
                n++;
                if (n == L + 1) begin
                    sb.push_back('{ch, cyc + 1});
                    n = 0;
                    got++;
                end
            end
            if (got < reps) @(negedge clk);
        end
    endtask

    task automatic next_tick(output int t);
        @(negedge clk);
        while (!tick0) @(negedge clk);
        t = cyc;
    endtask

    initial begin
        logic [31:0] a0, a1;
        int t1, t2;
        repeat (2) @(negedge clk);
        // reset state, read while held in reset
        rd(ad(0, SEL_RELOAD), a0, a1);
        chk(a0 == 3, "R1 reset prescaler reload", a0, 3);
        rd(ad(3, SEL_CTRL), a0, a1);
        chk(a0 == 1, "R8 watchdog control", a0, 1);
        rd(ad(3, SEL_COUNT), a0, a1);
        chk(a0 == WD, "R8 watchdog count", a0, WD);
        rd(ad(1, SEL_CTRL), a0, a1);
        chk(a0 == 0, "R8 timer0 control", a0, 0);
        rd(ad(2, SEL_RELOAD), a0, a1);
        chk(a0 == 0, "R10 timer1 reload", a0, 0);
        chk(wdog0 == 0 && wdog1 == 0, "R9 reset flag", wdog0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // watchdog timeout from reset
        count_uf(2, WD, 1);
        @(negedge clk);
        chk(wdog0 == 0, "R9 flag not before pulse", wdog0, 0);
        @(negedge clk);
        chk(wdog0 == 1 && wdog1 == 1, "R9 watchdog flag set", {wdog0, wdog1}, 2'b11);

        // tick spacing at reset reload
        next_tick(t1);
        @(negedge clk);
        chk(tick0 == 0, "R1 tick one cycle wide", tick0, 0);
        next_tick(t2);
        chk(t2 - t1 == 4, "R1 tick spacing 4", t2 - t1, 4);

        // new prescaler reload
        wr(ad(0, SEL_RELOAD), 32'd5);
        next_tick(t1);
        next_tick(t1);
        next_tick(t2);
        chk(t2 - t1 == 6, "R1 tick spacing 6", t2 - t1, 6);

        // one-shot timer 0
        wr(ad(1, SEL_RELOAD), 32'd3);
        wr(ad(1, SEL_CTRL), 32'b101);
        @(negedge clk);
        rd(ad(1, SEL_CTRL), a0, a1);
        chk(a0 == 1, "R5 load bit reads zero", a0, 1);
        rd(ad(1, SEL_COUNT), a0, a1);
        chk(a0 == 3, "R5 load copies reload", a0, 3);
        count_uf(0, 3, 1);
        repeat (2) @(negedge clk);
        rd(ad(1, SEL_CTRL), a0, a1);
        chk(a0 == 0, "R4 enable cleared", a0, 0);
        rd(ad(1, SEL_COUNT), a0, a1);
        chk(a0 == 16'hFFFF, "R4 counter wraps", a0, 16'hFFFF);
        repeat (40) @(negedge clk);

        // disabled timer holds
        wr(ad(2, SEL_RELOAD), 32'd7);
        wr(ad(2, SEL_CTRL), 32'b100);
        @(negedge clk);
        rd(ad(2, SEL_COUNT), a0, a1);
        chk(a0 == 7, "R5 load while disabled", a0, 7);
        repeat (30) @(negedge clk);
        rd(ad(2, SEL_COUNT), a0, a1);
        chk(a0 == 7, "R11 disabled counter holds", a0, 7);

        // auto-reload timer 1
        wr(ad(2, SEL_RELOAD), 32'd2);
        wr(ad(2, SEL_CTRL), 32'b111);
        @(negedge clk);
        count_uf(1, 2, 3);
        wr(ad(2, SEL_CTRL), 32'd0);
        chk(sb.size() == 0, "R3 auto-reload pulses on time", sb.size(), 0);
        rd(ad(2, SEL_CTRL), a0, a1);
        chk(a0 == 0, "R10 control readback", a0, 0);
        repeat (40) @(negedge clk);

        // watchdog channel as plain timer, flag stays
        wr(ad(3, SEL_RELOAD), 32'd1);
        wr(ad(3, SEL_CTRL), 32'b101);
        @(negedge clk);
        count_uf(2, 1, 1);
        repeat (3) @(negedge clk);
        chk(wdog0 == 1 && wdog1 == 1, "R9 flag sticky", {wdog0, wdog1}, 2'b11);

        repeat (10) @(negedge clk);
        chk(sb.size() == 0, "R2 all interrupts seen", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 run timeout actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule